// File: doc/BRIEF.md
# Word-to-Byte Multiplexed Bus Sequencer

This block sits between a CPU core that handles 16-bit words and an external memory bus with eight data lines and a 14-bit address. The core asks for one word operation at a time with a request and a one-cycle done pulse. The block turns each word into two byte cycles on the bus: first the even byte address, which carries the high byte, then the odd address, which carries the low byte. It drives the memory-enable, write-enable and data-in strobes and stretches each byte cycle while the memory holds READY low.

Four operations exist. A read joins the two bytes into a word. A write splits a word into two bytes. An instruction fetch reads the word at the internal program counter, raises an acquisition flag during the first byte cycle, loads the word into the instruction register and steps the counter by two. A byte store reads the whole destination word, replaces one byte and writes the whole word back. A separate load input sets the program counter while the block is idle.

The controller is one state machine. IDLE goes to HI_T1 when a request is accepted. HI_T1 always goes to HI_T2. From HI_T2 the machine goes to LO_T1 if READY is high and to HI_W1 if it is low. HI_W1 always goes to HI_W2. HI_W2 branches on READY in the same way as HI_T2. LO_T1 always goes to LO_T2. From LO_T2 the machine goes to LO_W1 if READY is low. If READY is high it goes to DONE, except on the read half of a byte store, where it goes back to HI_T1 for the write half. LO_W1 always goes to LO_W2, and LO_W2 branches on READY in the same way as LO_T2. DONE always goes to IDLE.

Top module: `byte_bus_seq`

## Requirements
- R1: During a transfer, `bus_addr` is the operation address cut to its low 14 bits, with bit 0 replaced by the byte lane. Address bits 15:14 from the core have no effect. The program counter always stays within 14 bits.
- R2: Every word operation makes byte transfers in pairs. The first transfer of a pair drives `bus_addr[0]`=0 and moves bits 15:8. The second drives `bus_addr[0]`=1 and moves bits 7:0.
- R3: Each byte transfer keeps `mem_en_n` low for 2 cycles, plus 2 cycles for each READY-low sample. READY is sampled on the second cycle and then on every second cycle after it. If a request is accepted at clock edge k, `done` is high in the cycle after edge k + 2·N + 2·W. Here N is the number of transfers (2, or 4 for a byte store) and W is the number of READY-low samples.
- R4: When `done` is high after a read or a fetch, `rdata` holds {first byte read, second byte read}.
- R5: `mem_en_n` is low only during transfers. `we_n` is low exactly during write transfers. `dbin` is high exactly during read transfers. During a write transfer, `bus_dout` carries the byte for that lane. When `done` is high after a write, `rdata` equals the word that was written.
- R6: Op code 3 (byte store) makes two read transfers and then two write transfers at the same pair of addresses. The written word is the word read, with byte `wdata[7:0]` placed in the high byte if address bit 0 is 0 and in the low byte if it is 1. `rdata` shows the written word.
- R7: Op code 2 (fetch) takes its address from the program counter. `iaq` is high for the whole first transfer and low at all other times. When `done` is high, `ir` holds the fetched word and `pc` holds (old pc + 2) with bit 0 cleared, masked to 14 bits, so 0x3FFE steps to 0x0000.
- R8: While READY holds a transfer, `bus_addr`, `bus_dout`, `mem_en_n`, `we_n`, `dbin` and `iaq` keep their values for the whole transfer.
- R9: The block accepts a request only in IDLE. A request held high, or changed, while the block is busy has no effect. `done` is a pulse one cycle long.
- R10: After reset, `mem_en_n`=1, `we_n`=1, `dbin`=0, `iaq`=0, `done`=0, `pc`=0 and `ir`=0.
- R11: `pc_load` in IDLE sets `pc` to `pc_in` with bit 0 cleared and masked to 14 bits, visible in the next cycle. In that cycle, `req` is not accepted. `pc_load` while busy has no effect. Op codes are 0 read, 1 write, 2 fetch, 3 byte store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Operation request from the core |
| op | input | 2 | Operation code: 0 read, 1 write, 2 fetch, 3 byte store |
| addr | input | 16 | Word address from the core |
| wdata | input | 16 | Write word; for a byte store, the byte is in bits 7:0 |
| pc_load | input | 1 | Load the program counter (honoured only in IDLE) |
| pc_in | input | 16 | Value loaded into the program counter |
| done | output | 1 | One-cycle pulse when the operation completes |
| rdata | output | 16 | Word read, written or merged |
| ir | output | 16 | Instruction register |
| pc | output | 16 | Program counter |
| bus_addr | output | 14 | External byte address |
| bus_dout | output | 8 | Byte driven to memory |
| bus_din | input | 8 | Byte returned by memory |
| mem_en_n | output | 1 | Memory enable, active low |
| we_n | output | 1 | Write enable, active low |
| dbin | output | 1 | High during read transfers |
| iaq | output | 1 | High during the first transfer of a fetch |
| ready | input | 1 | Memory ready; low inserts wait cycles |

## Verification
The bench models a memory that holds READY low for a chosen number of samples on each transfer. Against that model it targets the following cases and the failures each one would expose:
- Wait counts that differ between the two byte transfers. A design that samples READY on the wrong cycle gives a transfer length that is off by one cycle, or ignores the waits.
- A byte store at even and at odd addresses. A design that skips the read-back, or merges into the wrong lane, writes a wrong byte back.
- A fetch from 0x3FFE. A design that keeps upper bits of the counter fails to wrap to 0x0000.
- A request kept high and changed during an operation, and a counter load while busy. A design that accepts either one shows extra bus transfers or a moved counter.
- Stability of the address, data and strobe lines across every wait cycle. A design that lets the lane switch early drives the odd address before the memory is ready.

// File: rtl/bbs_pkg.sv
package bbs_pkg;

    typedef enum logic [1:0] {
        OP_READ   = 2'd0,
        OP_WRITE  = 2'd1,
        OP_FETCH  = 2'd2,
        OP_BSTORE = 2'd3
    } bbs_op_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_HI_T1,
        ST_HI_T2,
        ST_HI_W1,
        ST_HI_W2,
        ST_LO_T1,
        ST_LO_T2,
        ST_LO_W1,
        ST_LO_W2,
        ST_DONE
    } bbs_state_e;

endpackage

// File: rtl/bbs_fsm.sv
module bbs_fsm
    import bbs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req,
    input  logic [1:0] op,
    input  logic       pc_load,
    input  logic       ready,
    output logic       accept,
    output logic       idle,
    output logic       cap_hi,
    output logic       cap_lo,
    output logic       merge,
    output logic       fetch_end,
    output logic       smp,
    output logic       lane_lo,
    output logic       done,
    output logic       mem_en_n,
    output logic       we_n,
    output logic       dbin,
    output logic       iaq
);

    bbs_state_e state_q, state_d;
    bbs_op_e    op_q;
    logic       wr_q;

    logic hi_end, lo_end, finish, again, xfer;

    assign hi_end = (state_q == ST_HI_T2) || (state_q == ST_HI_W2);
    assign lo_end = (state_q == ST_LO_T2) || (state_q == ST_LO_W2);
    assign smp    = hi_end || lo_end;
    assign accept = (state_q == ST_IDLE) && req && !pc_load;
    assign finish = lo_end && ready;
    assign again  = finish && (op_q == OP_BSTORE) && !wr_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept) state_d = ST_HI_T1;
            ST_HI_T1: state_d = ST_HI_T2;
            ST_HI_T2,
            ST_HI_W2: state_d = ready ? ST_LO_T1 : ST_HI_W1;
            ST_HI_W1: state_d = ST_HI_W2;
            ST_LO_T1: state_d = ST_LO_T2;
            ST_LO_T2,
            ST_LO_W2: begin
                if (!ready)     state_d = ST_LO_W1;
                else if (again) state_d = ST_HI_T1;
                else            state_d = ST_DONE;
            end
            ST_LO_W1: state_d = ST_LO_W2;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register and per-operation flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            op_q    <= OP_READ;
            wr_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                op_q <= bbs_op_e'(op);
                wr_q <= (bbs_op_e'(op) == OP_WRITE);
            end else if (again) begin
                wr_q <= 1'b1;
            end
        end
    end

    // outputs decoded from the state
    always_comb begin
        xfer    = 1'b0;
        lane_lo = 1'b0;
        idle    = 1'b0;
        done    = 1'b0;
        unique case (state_q)
            ST_IDLE:  idle = 1'b1;
            ST_HI_T1, ST_HI_T2, ST_HI_W1, ST_HI_W2: xfer = 1'b1;
            ST_LO_T1, ST_LO_T2, ST_LO_W1, ST_LO_W2: begin
                xfer    = 1'b1;
                lane_lo = 1'b1;
            end
            ST_DONE:  done = 1'b1;
            default:  idle = 1'b0;
        endcase
        mem_en_n  = !xfer;
        we_n      = !(xfer && wr_q);
        dbin      = xfer && !wr_q;
        iaq       = xfer && !lane_lo && (op_q == OP_FETCH);
        cap_hi    = hi_end && ready && !wr_q;
        cap_lo    = lo_end && ready && !wr_q;
        merge     = again;
        fetch_end = finish && (op_q == OP_FETCH);
    end

    // R9: completion pulse lasts a single cycle
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5: write strobe only inside an enabled, non-read cycle
    a_r5_we_in_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> (!mem_en_n && !dbin));

    // R7: acquisition flag only on the first (high) byte of a transfer
    a_r7_iaq_first: assert property (@(posedge clk) disable iff (!rst_n)
        iaq |-> (!mem_en_n && !lane_lo));

    // R8: a READY-low sample keeps the transfer and its strobes unchanged
    a_r8_wait_held: assert property (@(posedge clk) disable iff (!rst_n)
        (smp && !ready) |=> (!mem_en_n && $stable(lane_lo) && $stable(we_n) && $stable(iaq)));

endmodule

// File: rtl/bbs_pc.sv
module bbs_pc #(
    parameter int CW = 16,
    parameter int AW = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pc_ld,
    input  logic [CW-1:0] pc_in,
    input  logic          fetch_end,
    output logic [CW-1:0] pc_q
);

    localparam logic [CW-1:0] PC_MASK = {{(CW-AW){1'b0}}, {(AW-1){1'b1}}, 1'b0};
    localparam logic [CW-1:0] STEP    = CW'(2);

    always_ff @(posedge clk) begin
        if (!rst_n)
            pc_q <= '0;
        else if (pc_ld)
            pc_q <= pc_in & PC_MASK;
        else if (fetch_end)
            pc_q <= (pc_q + STEP) & PC_MASK;
    end

    // R11: the counter moves only on a load or at the end of a fetch
    a_r11_pc_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!pc_ld && !fetch_end) |=> $stable(pc_q));

endmodule

// File: rtl/bbs_datapath.sv
module bbs_datapath #(
    parameter int CW = 16,
    parameter int AW = 14,
    parameter int BW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            accept,
    input  logic            is_fetch,
    input  logic [CW-1:0]   addr,
    input  logic [2*BW-1:0] wdata,
    input  logic [CW-1:0]   pc,
    input  logic            cap_hi,
    input  logic            cap_lo,
    input  logic            merge,
    input  logic            fetch_end,
    input  logic            smp,
    input  logic            ready,
    input  logic            lane_lo,
    input  logic [BW-1:0]   bus_din,
    output logic [AW-1:0]   bus_addr,
    output logic [BW-1:0]   bus_dout,
    output logic [2*BW-1:0] rdata,
    output logic [2*BW-1:0] ir
);

    localparam int WW    = 2 * BW;
    localparam int LANES = WW / BW;

    logic [AW-1:0] addr_q;
    logic [BW-1:0] wbyte_q;
    logic [WW-1:0] word_w;
    logic [WW-1:0] ir_q;
    logic          unused_hi;

    assign unused_hi = ^{addr[CW-1:AW], pc[CW-1:AW]};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wbyte_q <= '0;
        end else if (accept) begin
            addr_q  <= is_fetch ? pc[AW-1:0] : addr[AW-1:0];
            wbyte_q <= wdata[BW-1:0];
        end
    end

    // one register per byte lane; lane 1 is the high (even-address) byte
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam bit IS_HI = (g == LANES - 1);
        logic [BW-1:0] lane_q;
        logic          cap_me, pick;

        assign cap_me = IS_HI ? cap_hi : cap_lo;
        assign pick   = merge && (addr_q[0] != IS_HI);

        always_ff @(posedge clk) begin
            if (!rst_n)
                lane_q <= '0;
            else if (accept)
                lane_q <= wdata[g*BW +: BW];
            else if (pick)
                lane_q <= wbyte_q;
            else if (cap_me)
                lane_q <= bus_din;
        end

        assign word_w[g*BW +: BW] = lane_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            ir_q <= '0;
        else if (fetch_end)
            ir_q <= {word_w[WW-1:BW], bus_din};
    end

    assign bus_addr = {addr_q[AW-1:1], lane_lo};
    assign bus_dout = lane_lo ? word_w[BW-1:0] : word_w[WW-1:BW];
    assign rdata    = word_w;
    assign ir       = ir_q;

    // R8: address and write data stay put across a held transfer
    a_r8_bus_held: assert property (@(posedge clk) disable iff (!rst_n)
        (smp && !ready) |=> ($stable(bus_addr) && $stable(bus_dout)));

endmodule

// File: rtl/byte_bus_seq.sv
module byte_bus_seq #(
    parameter int CW = 16,
    parameter int AW = 14,
    parameter int BW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req,
    input  logic [1:0]      op,
    input  logic [CW-1:0]   addr,
    input  logic [2*BW-1:0] wdata,
    input  logic            pc_load,
    input  logic [CW-1:0]   pc_in,
    output logic            done,
    output logic [2*BW-1:0] rdata,
    output logic [2*BW-1:0] ir,
    output logic [CW-1:0]   pc,
    output logic [AW-1:0]   bus_addr,
    output logic [BW-1:0]   bus_dout,
    input  logic [BW-1:0]   bus_din,
    output logic            mem_en_n,
    output logic            we_n,
    output logic            dbin,
    output logic            iaq,
    input  logic            ready
);
    import bbs_pkg::*;

    logic accept, idle, cap_hi, cap_lo, merge, fetch_end, smp, lane_lo;
    logic pc_ld, is_fetch;

    assign pc_ld    = pc_load && idle;
    assign is_fetch = (bbs_op_e'(op) == OP_FETCH);

    bbs_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .op        (op),
        .pc_load   (pc_load),
        .ready     (ready),
        .accept    (accept),
        .idle      (idle),
        .cap_hi    (cap_hi),
        .cap_lo    (cap_lo),
        .merge     (merge),
        .fetch_end (fetch_end),
        .smp       (smp),
        .lane_lo   (lane_lo),
        .done      (done),
        .mem_en_n  (mem_en_n),
        .we_n      (we_n),
        .dbin      (dbin),
        .iaq       (iaq)
    );

    bbs_pc #(.CW(CW), .AW(AW)) u_pc (
        .clk       (clk),
        .rst_n     (rst_n),
        .pc_ld     (pc_ld),
        .pc_in     (pc_in),
        .fetch_end (fetch_end),
        .pc_q      (pc)
    );

    bbs_datapath #(.CW(CW), .AW(AW), .BW(BW)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .is_fetch  (is_fetch),
        .addr      (addr),
        .wdata     (wdata),
        .pc        (pc),
        .cap_hi    (cap_hi),
        .cap_lo    (cap_lo),
        .merge     (merge),
        .fetch_end (fetch_end),
        .smp       (smp),
        .ready     (ready),
        .lane_lo   (lane_lo),
        .bus_din   (bus_din),
        .bus_addr  (bus_addr),
        .bus_dout  (bus_dout),
        .rdata     (rdata),
        .ir        (ir)
    );

endmodule

// File: tb/tb_byte_bus_seq.sv
`timescale 1ns/1ps
module tb_byte_bus_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [1:0]  op = 2'd0;
    logic [15:0] addr = '0;
    logic [15:0] wdata = '0;
    logic        pc_load = 1'b0;
    logic [15:0] pc_in = '0;
    logic        done;
    logic [15:0] rdata, ir, pc;
    logic [13:0] bus_addr;
    logic [7:0]  bus_dout, bus_din;
    logic        mem_en_n, we_n, dbin, iaq;
    logic        ready = 1'b0;

    int nchk = 0;
    int nfail = 0;
    bit finished = 0;
    bit armed = 0;
    logic [15:0] pc_model = '0;

    // memory-side bookkeeping
    int          wq [8];
    logic [13:0] xa [8];
    logic        xwe [8];
    logic        xdb [8];
    logic        xiq [8];
    logic [7:0]  xdo [8];
    int          xl [8];
    int          xi = 0;
    int          n = 0;
    int          stab_err = 0;
    int          idle_err = 0;

    function automatic logic [7:0] mb(input logic [13:0] a);
        return a[7:0] ^ {a[13:8], a[13:12]} ^ 8'hA5;
    endfunction

    assign bus_din = mb(bus_addr);

    always #10 clk = ~clk;

    byte_bus_seq dut (
        .clk(clk), .rst_n(rst_n), .req(req), .op(op), .addr(addr), .wdata(wdata),
        .pc_load(pc_load), .pc_in(pc_in), .done(done), .rdata(rdata), .ir(ir), .pc(pc),
        .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_din(bus_din),
        .mem_en_n(mem_en_n), .we_n(we_n), .dbin(dbin), .iaq(iaq), .ready(ready)
    );

    // memory model: holds READY low for wq[xi] samples per transfer
    always @(negedge clk) begin
        if (armed) begin
            if (mem_en_n === 1'b0) begin
                if (xi < 8) begin
                    if (n == 0) begin
                        xa[xi] = bus_addr; xwe[xi] = we_n; xdb[xi] = dbin;
                        xiq[xi] = iaq; xdo[xi] = bus_dout;
                    end else if (xa[xi] !== bus_addr || xwe[xi] !== we_n || xdb[xi] !== dbin ||
                                 xiq[xi] !== iaq || (we_n === 1'b0 && xdo[xi] !== bus_dout)) begin
                        stab_err++;
                    end
                end
                n++;
                if (xi < 8 && n == 2 * wq[xi] + 2) begin
                    ready = 1'b1;
                    xl[xi] = n;
                    xi++;
                    n = 0;
                end else begin
                    ready = 1'b0;
                end
            end else begin
                ready = 1'b0;
                if (we_n !== 1'b1 || dbin !== 1'b0 || iaq !== 1'b0) idle_err++;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic load_pc(input logic [15:0] v, input bit with_req);
        @(negedge clk);
        pc_load = 1'b1; pc_in = v; req = with_req; op = 2'd0; addr = 16'h0040;
        @(negedge clk);
        pc_load = 1'b0; req = 1'b0;
        pc_model = v & 16'h3FFE;
        chk(pc == pc_model, "R11 pc load masked", pc, pc_model);
        chk(mem_en_n == 1'b1, "R11 req ignored under load", mem_en_n, 1);
        @(negedge clk);
        chk(mem_en_n == 1'b1, "R11 req ignored under load later", mem_en_n, 1);
    endtask

    task automatic run_op(input logic [1:0] o, input logic [15:0] a, input logic [15:0] wd,
                          input int wfix, input bit busy);
        int nx, sumw, c, expc;
        logic [13:0] base, ahi, alo, ea;
        logic [15:0] rd, exprd, expw, pcn;
        logic [7:0]  eb;
        bit wp;
        nx = (o == 2'd3) ? 4 : 2;
        sumw = 0;
        for (int i = 0; i < 8; i++) begin
            wq[i] = (wfix >= 0) ? wfix : int'($urandom_range(0, 3));
            if (i < nx) sumw += wq[i];
        end
        base = (o == 2'd2) ? pc_model[13:0] : a[13:0];
        ahi = {base[13:1], 1'b0};
        alo = {base[13:1], 1'b1};
        rd = {mb(ahi), mb(alo)};
        case (o)
            2'd0, 2'd2: exprd = rd;
            2'd1:       exprd = wd;
            default:    exprd = base[0] ? {rd[15:8], wd[7:0]} : {wd[7:0], rd[7:0]};
        endcase
        expw = exprd;
        xi = 0; n = 0; stab_err = 0;
        @(negedge clk);
        req = 1'b1; op = o; addr = a; wdata = wd;
        @(negedge clk);
        c = 0;
        if (busy) begin
            addr = a ^ 16'h1554; op = 2'd1;
        end else begin
            req = 1'b0;
        end
        while (done !== 1'b1 && c < 200) begin
            @(negedge clk);
            c++;
            if (busy && c == 1) begin pc_load = 1'b1; pc_in = 16'h1234; end
            if (c == 2) begin req = 1'b0; pc_load = 1'b0; end
        end
        expc = 2 * nx + 2 * sumw;
        chk(c == expc, "R3 done timing", c, expc);
        chk(rdata == exprd, (o == 2'd3) ? "R6 merged word" : (o == 2'd1 ? "R5 written word" : "R4 assembled word"), rdata, exprd);
        chk(xi == nx, "R9 transfer count", xi, nx);
        for (int i = 0; i < nx && i < 8; i++) begin
            wp = (o == 2'd1) || (o == 2'd3 && i >= 2);
            ea = i[0] ? alo : ahi;
            chk(xa[i] == ea, "R1/R2 byte address", xa[i], ea);
            chk(xl[i] == 2 + 2 * wq[i], "R3 transfer length", xl[i], 2 + 2 * wq[i]);
            chk(xwe[i] == !wp, "R5 write strobe", xwe[i], !wp);
            chk(xdb[i] == !wp, "R5 read strobe", xdb[i], !wp);
            if (wp) begin
                eb = i[0] ? expw[7:0] : expw[15:8];
                chk(xdo[i] == eb, (o == 2'd3) ? "R6 written byte" : "R5 written byte", xdo[i], eb);
            end
            chk(xiq[i] == (o == 2'd2 && i == 0), "R7 iaq window", xiq[i], (o == 2'd2 && i == 0));
        end
        chk(stab_err == 0, "R8 held lines", stab_err, 0);
        if (o == 2'd2) begin
            pcn = (pc_model + 16'd2) & 16'h3FFE;
            chk(ir == rd, "R7 instruction word", ir, rd);
            chk(pc == pcn, "R7 pc step", pc, pcn);
            pc_model = pcn;
        end else begin
            chk(pc == pc_model, "R11 pc unchanged", pc, pc_model);
        end
        @(negedge clk);
        chk(done == 1'b0, "R9 done single cycle", done, 0);
    endtask

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        armed = 1'b1;
        chk(mem_en_n == 1'b1, "R10 mem_en_n", mem_en_n, 1);
        chk(we_n == 1'b1, "R10 we_n", we_n, 1);
        chk(dbin == 1'b0, "R10 dbin", dbin, 0);
        chk(iaq == 1'b0, "R10 iaq", iaq, 0);
        chk(done == 1'b0, "R10 done", done, 0);
        chk(pc == 16'h0000, "R10 pc", pc, 0);
        chk(ir == 16'h0000, "R10 ir", ir, 0);

        load_pc(16'hFFFF, 1'b1);
        run_op(2'd2, 16'h0000, 16'h0000, 0, 1'b0);   // wrap 3FFE -> 0000
        run_op(2'd0, 16'hC001, 16'h0000, 0, 1'b0);   // upper bits masked
        run_op(2'd1, 16'h1235, 16'hBEEF, 2, 1'b0);
        run_op(2'd3, 16'h0100, 16'h00C3, 1, 1'b0);   // byte store, even
        run_op(2'd3, 16'h4101, 16'h005A, 0, 1'b0);   // byte store, odd
        run_op(2'd0, 16'h2222, 16'h0000, 3, 1'b1);   // busy request and load
        load_pc(16'h0011, 1'b0);
        run_op(2'd2, 16'h0000, 16'h0000, -1, 1'b0);
        run_op(2'd2, 16'h0000, 16'h0000, -1, 1'b0);
        for (int k = 0; k < 40; k++) begin
            run_op(2'($urandom_range(0, 3)), 16'($urandom()), 16'($urandom()), -1, 1'b0);
        end
        chk(idle_err == 0, "R5 strobes quiet between transfers", idle_err, 0);

        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            nchk++;
            nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

endmodule